// File: doc/BRIEF.md
# Port Status Indicator Encoder

This block turns the receive-side link state of one port into two indicator outputs. The first is a tri-state speed output. It drives high while a 100 Mbps signal is present and drives low while only a 10 Mbps signal is present. It floats when no signal of either rate is present. A signal counts as present whether it carries idle symbols or packets. The second is an open-drain activity output, and what it means depends on the speed output. While the speed output floats, the activity output pulls low whenever auto-negotiation signalling arrives. While a speed is detected, it pulls low for packet activity, and each packet strobe is stretched so that a short packet still gives a visible LED blink.

Stretching uses a free-running prescaler that emits one tick every millisecond-scale period. The tick period is set by the clock frequency and tick-length parameters. A packet strobe loads a small counter and each tick counts it down. The guaranteed low time therefore lies between one and two tick periods. All outputs are registered, so every output reflects the inputs sampled on the previous clock edge.

Top module: `led_port_status`

## Requirements
- R1: With `sig100_i` high at a clock edge, after that edge `spd_oe_o`=1 and `spd_o`=1.
- R2: With `sig10_i` high and `sig100_i` low at an edge, after that edge `spd_oe_o`=1 and `spd_o`=0.
- R3: With both `sig10_i` and `sig100_i` high, the 100 Mbps encoding wins (`spd_o`=1).
- R4: With neither speed flag high, after the edge `spd_oe_o`=0 and `spd_o`=0 (floating).
- R5: While no speed is present, `act_pd_o` equals `aneg_i` sampled at the previous edge, and `pkt_i` has no effect.
- R6: While a speed is present, `act_pd_o` depends on packet stretching only, and `aneg_i` has no effect.
- R7: A single `pkt_i` strobe with the speed held keeps `act_pd_o`=1 for between TICK_CYCLES+1 and 2*TICK_CYCLES cycles.
- R8: A `pkt_i` strobe during a stretch reloads it, so the low time counts from the last strobe.
- R9: Losing the speed clears the stretch at once: from the next edge `act_pd_o` follows `aneg_i` and the stretch does not resume when the speed returns.
- R10: Asynchronous active-low reset clears the prescaler and stretch, with all outputs 0 (both pins floating).
- R11: The prescaler ticks every TICK_CYCLES = (CLK_FREQ_HZ/1e6)*TICK_US clocks from reset release. A strobe at the first edge after reset gives exactly 2*TICK_CYCLES-1 low cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig100_i | input | 1 | 100 Mbps signal present |
| sig10_i | input | 1 | 10 Mbps signal present |
| aneg_i | input | 1 | Auto-negotiation signalling being received |
| pkt_i | input | 1 | One-cycle packet-detect strobe |
| spd_o | output | 1 | Speed pin value: 1 = 100 Mbps, 0 = 10 Mbps |
| spd_oe_o | output | 1 | Speed pin drive enable; 0 = floating |
| act_pd_o | output | 1 | Activity pull-down enable; 1 = pin pulled low, 0 = floating |

## Verification
The bench builds the block with CLK_FREQ_HZ = 4 MHz and TICK_US = 5, so a tick falls every 20 clocks instead of every 168,750. With that setting, full stretch windows, retriggers in the middle of a stretch and speed loss at every prescaler phase all fit into a few thousand random cycles. The tick phase at reset release is also known. That makes the exact low time of R11 directly measurable, in addition to the window of R7.

// File: rtl/led_status_pkg.sv
package led_status_pkg;
  typedef enum logic [1:0] {
    SPD_NONE = 2'd0,
    SPD_10   = 2'd1,
    SPD_100  = 2'd2
  } spd_e;

  function automatic int tick_cycles(input int clk_hz, input int tick_us);
    int c;
    c = (clk_hz / 1_000_000) * tick_us;
    return (c < 2) ? 2 : c;
  endfunction
endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int TICK_CYCLES = 168_750,
  localparam int PRE_W = $clog2(TICK_CYCLES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic [PRE_W-1:0] pre_q;

  assign tick_o = (pre_q == PRE_W'(TICK_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/led_speed_enc.sv
module led_speed_enc
  import led_status_pkg::*;
(
  input  logic sig100_i,
  input  logic sig10_i,
  output spd_e spd_o,
  output logic present_o
);
  always_comb begin
    if (sig100_i)     spd_o = SPD_100;
    else if (sig10_i) spd_o = SPD_10;
    else              spd_o = SPD_NONE;
  end
  assign present_o = (spd_o != SPD_NONE);
endmodule

// File: rtl/led_act_stretch.sv
module led_act_stretch #(
  parameter int STRETCH_LOAD = 2,
  localparam int CNT_W = $clog2(STRETCH_LOAD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic present_i,
  input  logic pkt_i,
  input  logic tick_i,
  output logic busy_d_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!present_i)                 cnt_d = '0;
    else if (pkt_i)                 cnt_d = CNT_W'(STRETCH_LOAD);
    else if (tick_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  assign busy_d_o = (cnt_d != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/led_port_status.sv
module led_port_status
  import led_status_pkg::*;
#(
  parameter int CLK_FREQ_HZ  = 125_000_000,
  parameter int TICK_US      = 1350,
  parameter int STRETCH_LOAD = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig100_i,
  input  logic sig10_i,
  input  logic aneg_i,
  input  logic pkt_i,
  output logic spd_o,
  output logic spd_oe_o,
  output logic act_pd_o
);
  localparam int TICK_CYCLES = tick_cycles(CLK_FREQ_HZ, TICK_US);

  logic tick;
  logic present;
  logic busy_d;
  spd_e spd_sel;

  led_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  led_speed_enc u_spd (
    .sig100_i  (sig100_i),
    .sig10_i   (sig10_i),
    .spd_o     (spd_sel),
    .present_o (present)
  );

  led_act_stretch #(.STRETCH_LOAD(STRETCH_LOAD)) u_act (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .present_i (present),
    .pkt_i     (pkt_i),
    .tick_i    (tick),
    .busy_d_o  (busy_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spd_o    <= 1'b0;
      spd_oe_o <= 1'b0;
      act_pd_o <= 1'b0;
    end else begin
      spd_o    <= (spd_sel == SPD_100);
      spd_oe_o <= present;
      // pin meaning switches with speed presence
      act_pd_o <= present ? busy_d : aneg_i;
    end
  end
endmodule

// File: rtl/led_port_status_chk.sv
module led_port_status_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sig100_i,
  input logic sig10_i,
  input logic aneg_i,
  input logic pkt_i,
  input logic spd_o,
  input logic spd_oe_o,
  input logic act_pd_o,
  input logic tick
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_spd_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(sig100_i) |-> spd_oe_o && spd_o);

  assert_spd_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(sig10_i && !sig100_i) |-> spd_oe_o && !spd_o);

  assert_spd_float_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!sig10_i && !sig100_i) |-> !spd_oe_o && !spd_o);

  assert_aneg_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !spd_oe_o |-> act_pd_o == $past(aneg_i));

  assert_pkt_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && spd_oe_o && $past(pkt_i) |-> act_pd_o);

  assert_release_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && spd_oe_o && $past(spd_oe_o) && $fell(act_pd_o) |-> $past(tick));

  assert_reset_float_R10: assert property (@(posedge clk_i)
    !rst_ni |-> !spd_oe_o && !act_pd_o && !spd_o);
endmodule

bind led_port_status led_port_status_chk u_chk (.*);

// File: tb/led_port_status_tb.sv
module led_port_status_tb;
  localparam int CLK_HZ = 4_000_000;
  localparam int TUS    = 5;
  localparam int TICK   = (CLK_HZ / 1_000_000) * TUS;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sig100_i = 1'b0, sig10_i = 1'b0, aneg_i = 1'b0, pkt_i = 1'b0;
  logic spd_o, spd_oe_o, act_pd_o;

  int n_chk = 0, n_bad = 0;
  int m_pre = 0, m_cnt = 0;
  logic m_spd = 0, m_oe = 0, m_act = 0;
  logic done = 0;

  always #2.5 clk_i = ~clk_i;

  led_port_status #(.CLK_FREQ_HZ(CLK_HZ), .TICK_US(TUS), .STRETCH_LOAD(2)) u_dut (
    .clk_i, .rst_ni, .sig100_i, .sig10_i, .aneg_i, .pkt_i,
    .spd_o, .spd_oe_o, .act_pd_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic next_act(input logic s100, input logic s10, input logic an,
                                    input logic pk, input logic tk, inout int cnt);
    if (!(s100 || s10))     cnt = 0;
    else if (pk)            cnt = 2;
    else if (tk && cnt > 0) cnt = cnt - 1;
    return (s100 || s10) ? (cnt != 0) : an;
  endfunction

  task automatic model_reset();
    m_pre = 0; m_cnt = 0; m_spd = 0; m_oe = 0; m_act = 0;
  endtask

  // one clock with given inputs; compare at the falling edge
  task automatic step(input logic s100, input logic s10, input logic an, input logic pk);
    logic tk;
    sig100_i = s100; sig10_i = s10; aneg_i = an; pkt_i = pk;
    @(posedge clk_i);
    tk = (m_pre == TICK - 1);
    m_pre = tk ? 0 : m_pre + 1;
    m_act = next_act(s100, s10, an, pk, tk, m_cnt);
    m_oe = s100 || s10;
    m_spd = s100;
    @(negedge clk_i);
    if (s100 && s10) chk("R3 spd_o", spd_o, 1);
    else if (s100)   chk("R1 spd_o", spd_o, 1);
    else if (s10)    chk("R2 spd_o", spd_o, 0);
    else             chk("R4 spd_o", spd_o, 0);
    chk(m_oe ? "R1/R2 spd_oe_o" : "R4 spd_oe_o", spd_oe_o, m_oe);
    chk(m_oe ? "R6 act_pd_o" : "R5 act_pd_o", act_pd_o, m_act);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; sig100_i = 0; sig10_i = 0; aneg_i = 0; pkt_i = 0;
    model_reset();
    #1;
    chk("R10 spd_oe_o", spd_oe_o, 0);
    chk("R10 act_pd_o", act_pd_o, 0);
    chk("R10 spd_o", spd_o, 0);
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  int low_cnt;

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();

    // R11: strobe on first edge after reset, exact low time
    step(1, 0, 0, 1);
    low_cnt = 1;
    while (act_pd_o && low_cnt < 4 * TICK) begin step(1, 0, 0, 0); if (act_pd_o) low_cnt++; end
    chk("R11 low cycles", low_cnt, 2 * TICK - 1);

    // R7: strobe at random phase, window check
    repeat (7) step(0, 1, 0, 0);
    step(0, 1, 0, 1);
    low_cnt = 1;
    while (act_pd_o && low_cnt < 4 * TICK) begin step(0, 1, 1, 0); if (act_pd_o) low_cnt++; end
    chk("R7 low in window", int'(low_cnt >= TICK + 1 && low_cnt <= 2 * TICK), 1);

    // R8: retrigger late in stretch extends low time past 2*TICK
    step(1, 1, 0, 1);
    repeat (TICK + 5) step(1, 1, 0, 0);
    step(1, 1, 0, 1);
    low_cnt = 0;
    while (act_pd_o && low_cnt < 4 * TICK) begin step(1, 1, 0, 0); low_cnt++; end
    chk("R8 held after retrigger", int'(low_cnt >= TICK), 1);

    // R9: speed loss mid-stretch clears it
    step(1, 0, 0, 1);
    step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    chk("R9 act after loss", act_pd_o, 0);
    step(1, 0, 0, 0);
    chk("R9 no resume", act_pd_o, 0);
    step(0, 0, 1, 1);
    chk("R5 aneg with pkt ignored", act_pd_o, 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic s100, s10, an, pk;
      int r = $urandom_range(0, 99);
      s100 = (r < 45);
      s10  = (r >= 30 && r < 80);
      an   = $urandom_range(0, 1) == 1;
      pk   = $urandom_range(0, 29) == 0;
      step(s100, s10, an, pk);
    end

    do_reset();
    step(0, 0, 1, 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule